// File: doc/BRIEF.md
# Write-Merging Command Buffer Builder

The block turns a stream of register-write requests into packed two-dword instructions. It stores them in a local buffer RAM that is addressed by dword. Each request carries a register offset, a 32-bit value and a 32-bit mask. The mask is reduced to per-byte enables. A request that writes the full register at the same offset as the instruction just emitted is not given a new instruction. The builder goes back and edits the earlier instruction instead: a single direct write becomes an indexed write with a count word, and later values are appended to it. The count is updated and the odd tail is padded with a zero word, all in place.

The same request port also accepts two other commands. A no-operation command emits an all-zero instruction. A finish command zero-fills the buffer up to the next 64-byte line. The builder keeps a free-position pointer and the start of the last instruction, and shows both on its outputs. A synchronous read port lets a consumer fetch any buffer word. Each request is a single valid/ready transfer, and ready stays low while the builder performs the RAM writes for that request, one word per cycle.

Top module: `cmdbuf_builder`

## Requirements
- R1: After a synchronous reset, free_pos and instr_start are 0, overflow is 0 and req_ready is 1. The buffer contents are not cleared.
- R2: A write that is not merged emits a direct instruction at an even start `s`. The value goes to word `s` and the header goes to word `s+1`. The header holds opcode 0x01 in bits 31:24, the byte enables in bits 23:20 and the offset in bits 19:0. Afterwards free_pos is `s+2` and instr_start is `s`, and ready is low for 2 cycles.
- R3: Byte-enable bit i (i = 0..3) is set exactly when mask bits 8i+7..8i contain a one.
- R4: A write merges only when all of the following hold: free_pos is nonzero, the request mask is all ones, the offset equals that of the last instruction, and the last instruction is either a direct write whose four byte enables are all set or an indexed write. A masked write, a write to another offset, or a write after a no-op always emits a new instruction.
- R5: Merging into a direct write at `s` rewrites its words. Word `s` becomes the count 2, word `s+1` becomes a header with opcode 0x09, zero in bits 23:20 and the offset in bits 19:0. Word `s+2` becomes the old value and word `s+3` the new value. free_pos then becomes `s+4`, and ready is low for 4 cycles.
- R6: Merging into an indexed write stores the value at free_pos, advances free_pos by one and increments the count word at instr_start. If the new free_pos is odd, the word at it is set to zero. Ready is low for 2 cycles, or 3 when the zero pad is written.
- R7: Every new instruction starts at free_pos rounded up to an even dword, so instr_start is always even.
- R8: A write or no-op that arrives while free_pos is greater than DEPTH-2 is dropped, and the buffer and pointers are left unchanged. It sets overflow, which stays set until reset. Ready does not drop for it.
- R9: A no-op (req_op 1) emits an instruction of two zero words and takes 2 cycles.
- R10: A finish (req_op 2) writes zero from free_pos up to the next multiple of 16 dwords, moves free_pos to that boundary and keeps ready low for one cycle per word filled. When free_pos is already on a boundary it does nothing. No write merges with an instruction emitted before a finish.
- R11: req_op 3 is accepted and has no effect. Requests are taken only while req_ready is high, and the pointers do not change while the builder is idle with no request.
- R12: rd_data shows the buffer word at rd_addr one clock after rd_addr is sampled.
- R13: After reset, the first write never merges, even when the stale buffer contents match the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Builder can take a request |
| req_op | input | 2 | 0 write, 1 no-op, 2 finish, 3 reserved |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Data value |
| req_mask | input | 32 | Bit mask reduced to byte enables |
| rd_addr | input | AW | Buffer read address (dword) |
| rd_data | output | 32 | Buffer word, one cycle after rd_addr |
| free_pos | output | PW | First free dword |
| instr_start | output | PW | Start dword of the last instruction |
| overflow | output | 1 | Sticky: a request found no room |

## Verification
The builder's merge decision is based on shadow registers, not on the buffer contents, so a wrong shadow state appears as a wrong instruction layout. The fault is visible on free_pos and instr_start when the request that follows completes, and in the buffer words read back afterwards. A miscounted step shows up at once as a ready-low window of the wrong length, which the bench compares cycle by cycle against a reference model that decides merges by inspecting its own copy of the buffer. Pointer faults near the buffer end are visible as a missing or spurious overflow on the request that hits the limit.

// File: rtl/cmdbuf_pkg.sv
`timescale 1ns/1ps
package cmdbuf_pkg;
  localparam int OFF_W = 20;
  localparam logic [7:0] OPC_NOOP    = 8'h00;
  localparam logic [7:0] OPC_DIRECT  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;

  typedef enum logic [1:0] {
    REQ_WRITE  = 2'd0,
    REQ_NOOP   = 2'd1,
    REQ_FINISH = 2'd2,
    REQ_RSVD   = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    LAST_OTHER,
    LAST_DIRECT_FULL,
    LAST_INDEXED
  } last_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEW_VAL, ST_NEW_HDR,
    ST_CV_CNT, ST_CV_HDR, ST_CV_OLD, ST_CV_NEW,
    ST_AP_VAL, ST_AP_CNT, ST_AP_PAD, ST_FILL
  } seq_st_e;

  function automatic logic [31:0] mk_hdr(logic [7:0] opc, logic [3:0] be,
                                         logic [OFF_W-1:0] off);
    return {opc, be, off};
  endfunction
endpackage

// File: rtl/cmdbuf_byte_en.sv
`timescale 1ns/1ps
module cmdbuf_byte_en #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] mask,
  output logic [LANES-1:0]   be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = |mask[8*g +: 8];
  end
endmodule

// File: rtl/cmdbuf_ram.sv
`timescale 1ns/1ps
module cmdbuf_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmdbuf_seq.sv
`timescale 1ns/1ps
module cmdbuf_seq
  import cmdbuf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int LINE_DW = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(LINE_DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [31:0]      req_value,
  input  logic [31:0]      req_mask,
  input  logic [3:0]       req_be,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [31:0]      wdata,
  output logic [PW-1:0]    free_pos,
  output logic [PW-1:0]    instr_start,
  output logic             overflow
);
  seq_st_e          st;
  last_kind_e       last_kind;
  logic [PW-1:0]    fp, start;
  logic [OFF_W-1:0] last_off;
  logic [31:0]      last_val, cnt, l_val, l_hdr;
  logic             ovf;

  logic [PW-1:0] fp_even, fp_inc;
  logic          no_room, mrg;

  assign fp_even = fp + PW'(fp[0]);
  assign fp_inc  = fp + PW'(1);
  assign no_room = fp > PW'(DEPTH - 2);
  assign mrg     = (&req_mask) && (fp != '0) && (last_kind != LAST_OTHER) &&
                   (last_off == req_offset);

  always_comb begin
    we    = 1'b1;
    waddr = AW'(fp);
    wdata = '0;
    case (st)
      ST_NEW_VAL: begin waddr = AW'(fp_even);        wdata = l_val; end
      ST_NEW_HDR: begin waddr = AW'(fp);             wdata = l_hdr; end
      ST_CV_CNT:  begin waddr = AW'(start);          wdata = 32'd2; end
      ST_CV_HDR:  begin waddr = AW'(start + PW'(1));
                        wdata = mk_hdr(OPC_INDEXED, 4'h0, last_off); end
      ST_CV_OLD:  begin waddr = AW'(start + PW'(2)); wdata = last_val; end
      ST_CV_NEW:  begin waddr = AW'(start + PW'(3)); wdata = l_val; end
      ST_AP_VAL:  begin waddr = AW'(fp);             wdata = l_val; end
      ST_AP_CNT:  begin waddr = AW'(start);          wdata = cnt; end
      ST_AP_PAD:  begin waddr = AW'(fp);             wdata = '0; end
      ST_FILL:    begin waddr = AW'(fp);             wdata = '0; end
      default:    we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      last_kind <= LAST_OTHER;
      fp        <= '0;
      start     <= '0;
      last_off  <= '0;
      last_val  <= '0;
      cnt       <= '0;
      l_val     <= '0;
      l_hdr     <= '0;
      ovf       <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          case (req_op_e'(req_op))
            REQ_WRITE: begin
              l_val <= req_value;
              if (no_room) ovf <= 1'b1;
              else if (mrg && last_kind == LAST_DIRECT_FULL) begin
                cnt       <= 32'd2;
                last_kind <= LAST_INDEXED;
                st        <= ST_CV_CNT;
              end else if (mrg) begin
                cnt <= cnt + 32'd1;
                st  <= ST_AP_VAL;
              end else begin
                l_hdr     <= mk_hdr(OPC_DIRECT, req_be, req_offset);
                last_kind <= (&req_be) ? LAST_DIRECT_FULL : LAST_OTHER;
                last_off  <= req_offset;
                last_val  <= req_value;
                cnt       <= 32'd1;
                st        <= ST_NEW_VAL;
              end
            end
            REQ_NOOP: begin
              if (no_room) ovf <= 1'b1;
              else begin
                l_val     <= '0;
                l_hdr     <= mk_hdr(OPC_NOOP, 4'h0, '0);
                last_kind <= LAST_OTHER;
                st        <= ST_NEW_VAL;
              end
            end
            REQ_FINISH: begin
              last_kind <= LAST_OTHER;
              if (fp[LW-1:0] != '0) st <= ST_FILL;
            end
            default: ;
          endcase
        end
        ST_NEW_VAL: begin start <= fp_even; fp <= fp_even + PW'(1); st <= ST_NEW_HDR; end
        ST_NEW_HDR: begin fp <= fp_inc; st <= ST_IDLE; end
        ST_CV_CNT:  st <= ST_CV_HDR;
        ST_CV_HDR:  st <= ST_CV_OLD;
        ST_CV_OLD:  st <= ST_CV_NEW;
        ST_CV_NEW:  begin fp <= start + PW'(4); st <= ST_IDLE; end
        ST_AP_VAL:  begin fp <= fp_inc; st <= ST_AP_CNT; end
        ST_AP_CNT:  st <= fp[0] ? ST_AP_PAD : ST_IDLE;
        ST_AP_PAD:  st <= ST_IDLE;
        ST_FILL: begin
          fp <= fp_inc;
          if (fp_inc[LW-1:0] == '0) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == ST_IDLE);
  assign free_pos    = fp;
  assign instr_start = start;
  assign overflow    = ovf;
endmodule

// File: rtl/cmdbuf_builder.sv
`timescale 1ns/1ps
module cmdbuf_builder #(
  parameter int DEPTH      = 64,
  parameter int LINE_BYTES = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [19:0]   req_offset,
  input  logic [31:0]   req_value,
  input  logic [31:0]   req_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data,
  output logic [PW-1:0] free_pos,
  output logic [PW-1:0] instr_start,
  output logic          overflow
);
  localparam int LINE_DW = LINE_BYTES / 4;

  logic [3:0]    be;
  logic          we;
  logic [AW-1:0] waddr;
  logic [31:0]   wdata;

  cmdbuf_byte_en #(.LANES(4)) u_be (
    .mask (req_mask),
    .be   (be)
  );

  cmdbuf_seq #(.DEPTH(DEPTH), .LINE_DW(LINE_DW)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_offset  (req_offset),
    .req_value   (req_value),
    .req_mask    (req_mask),
    .req_be      (be),
    .we          (we),
    .waddr       (waddr),
    .wdata       (wdata),
    .free_pos    (free_pos),
    .instr_start (instr_start),
    .overflow    (overflow)
  );

  cmdbuf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/cmdbuf_builder_chk.sv
`timescale 1ns/1ps
module cmdbuf_builder_chk #(
  parameter int DEPTH = 64,
  parameter int PW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [PW-1:0] free_pos,
  input logic [PW-1:0] instr_start,
  input logic          overflow
);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_op[1] && (int'(free_pos) > DEPTH - 2))
    |=> ($stable(free_pos) && overflow));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid) |=> ($stable(free_pos) && $stable(instr_start)));

  // R7
  start_even_chk: assert property (@(posedge clk) disable iff (rst)
    instr_start[0] == 1'b0);

  // R10
  fp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(free_pos) <= DEPTH);

  // R10
  fp_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> free_pos >= $past(free_pos));
endmodule

bind cmdbuf_builder cmdbuf_builder_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .free_pos    (free_pos),
  .instr_start (instr_start),
  .overflow    (overflow)
);

// File: tb/cmdbuf_builder_tb.sv
`timescale 1ns/1ps
module cmdbuf_builder_tb;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [31:0] FULL = 32'hFFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [19:0]   req_offset = '0;
  logic [31:0]   req_value = '0;
  logic [31:0]   req_mask = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [PW-1:0] free_pos, instr_start;
  logic          overflow;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [31:0] m [DEPTH];
  int r_fp = 0, r_st = 0, r_ovf = 0, r_fence = 0;

  always #10 clk = ~clk;

  cmdbuf_builder #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_offset(req_offset), .req_value(req_value),
    .req_mask(req_mask), .rd_addr(rd_addr), .rd_data(rd_data),
    .free_pos(free_pos), .instr_start(instr_start), .overflow(overflow)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic emit(logic [31:0] val, logic [31:0] hdr);
    r_fp = r_fp + (r_fp & 1);
    r_st = r_fp;
    m[r_fp] = val;
    m[r_fp + 1] = hdr;
    r_fp += 2;
    r_fence = 0;
  endtask

  task automatic ref_apply(int op, int off, logic [31:0] val, logic [31:0] mask,
                           output int busy);
    logic [31:0] ph;
    logic [3:0]  be;
    bit ok;
    busy = 0;
    if (op == 0) begin
      if (r_fp > DEPTH - 2) begin r_ovf = 1; return; end
      ph = m[r_st + 1];
      ok = (r_fp != 0) && !r_fence && (mask == FULL) && (ph[19:0] == off[19:0]) &&
           ((ph[31:20] == 12'h01F) || (ph[31:20] == 12'h090));
      if (ok) begin
        if (ph[31:20] == 12'h01F) begin
          m[r_st + 2] = m[r_st];
          m[r_st] = 32'd1;
          m[r_st + 1] = {8'h09, 4'h0, off[19:0]};
          r_fp++;
          busy = 4;
        end else busy = 2;
        m[r_fp] = val;
        r_fp++;
        m[r_st] = m[r_st] + 1;
        if (r_fp % 2 == 1) begin
          m[r_fp] = 0;
          if (busy == 2) busy = 3;
        end
      end else begin
        for (int l = 0; l < 4; l++) be[l] = (mask[8*l +: 8] != 0);
        emit(val, {8'h01, be, off[19:0]});
        busy = 2;
      end
    end else if (op == 1) begin
      if (r_fp > DEPTH - 2) begin r_ovf = 1; return; end
      emit(0, 0);
      busy = 2;
    end else if (op == 2) begin
      r_fence = 1;
      while (r_fp % 16 != 0) begin m[r_fp] = 0; r_fp++; busy++; end
    end
  endtask

  task automatic check_ptrs(string req);
    chk(int'(free_pos) == r_fp, {req, " free_pos"}, int'(free_pos), r_fp);
    chk(int'(instr_start) == r_st, {req, " instr_start"}, int'(instr_start), r_st);
    chk(int'(overflow) == r_ovf, {req, " overflow"}, int'(overflow), r_ovf);
  endtask

  task automatic send(int op, int off, logic [31:0] val, logic [31:0] mask, string req);
    int busy;
    int n;
    ref_apply(op, off, val, mask, busy);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_offset = off[19:0];
    req_value = val; req_mask = mask;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!req_ready && n < 100) begin n++; @(negedge clk); end
    chk(n == busy, {req, " ready-low cycles"}, n, busy);
    check_ptrs(req);
  endtask

  task automatic compare_mem(string req);
    for (int a = 0; a < r_fp; a++) begin
      @(negedge clk);
      rd_addr = AW'(a);
      @(negedge clk);
      chk(rd_data === m[a], $sformatf("%s word %0d", req, a), int'(rd_data), int'(m[a]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    r_fp = 0; r_st = 0; r_ovf = 0; r_fence = 0;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check_ptrs("R1");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m[i] = 0;
    do_reset();
    send(0, 'h123, 32'd11, FULL, "R2 first direct write");
    send(0, 'h123, 32'd22, FULL, "R5 convert to indexed");
    send(0, 'h123, 32'd33, FULL, "R6 append with pad");
    send(0, 'h123, 32'd44, FULL, "R6 append even");
    send(0, 'h200, 32'hAABBCCDD, 32'h00FF0000, "R3 partial mask");
    send(0, 'h200, 32'd55, FULL, "R4 no merge into partial");
    send(0, 'h300, 32'd66, 32'h01010101, "R3 sparse mask all lanes");
    send(0, 'h300, 32'd77, FULL, "R4 merge into full-enable direct");
    send(0, 'h300, 32'd88, FULL, "R6 append pad odd");
    send(0, 'h400, 32'd99, FULL, "R7 align odd free_pos");
    send(1, 0, 0, 0, "R9 noop");
    send(0, 'h400, 32'd100, FULL, "R4 no merge after noop");
    send(3, 'h400, 32'd101, FULL, "R11 reserved op");
    send(2, 0, 0, 0, "R10 finish fill");
    send(2, 0, 0, 0, "R10 finish aligned");
    send(0, 'h400, 32'd102, FULL, "R10 no merge across finish");
    compare_mem("R12 readback");
    for (int i = 0; i < 14; i++)
      send(0, 'h500 + i, 32'd200 + i, FULL, "R2 fill to end");
    send(0, 'h500 + 13, 32'd300, FULL, "R5 convert at end");
    send(0, 'h600, 32'd301, FULL, "R8 write rejected");
    send(1, 0, 0, 0, "R8 noop rejected");
    send(0, 'h500 + 13, 32'd302, FULL, "R8 merge rejected");
    send(2, 0, 0, 0, "R10 finish full buffer");
    compare_mem("R8 buffer unchanged");
    do_reset();
    send(0, 'h123, 32'd400, FULL, "R13 no merge on stale data");
    send(2, 0, 0, 0, "R10 finish after reset");
    compare_mem("R13 readback");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule